// File: doc/BRIEF.md
# Compressed Instruction Expander

This unit sits in the decode stage of a small pipelined core that fetches 32-bit words. It can run in two modes. In full-width mode the fetch word is already an instruction and goes straight to the decoder. In compressed mode one 16-bit half of the fetch word is picked out and rewritten into the equivalent 32-bit instruction. The decoder then runs that instruction like any other.

The 16-bit forms omit operands and can only name registers 0 to 7. The expander fills in the implied fields, sets the flag-update bit for arithmetic, and gives every expanded instruction the always-execute condition. Conditional branches are the one exception: they keep their own condition. Any pattern outside the supported forms becomes a no-operation and raises a flag. The unit is purely combinational, so it adds no pipeline cycle.

Full-width layout used by the outputs:
- cond is bits [31:28]; always-execute is 4'hE.
- op is bits [27:24]: 0 add-reg, 1 sub-reg, 2 move-imm, 3 compare-imm, 4 add-imm, 8 branch, D no-op.
- The set-flags bit S is bit [23].
- rd is bits [22:19] and rn is bits [18:15].
- Register form: rm is bits [14:11] and bits [10:0] are zero.
- Immediate form: bits [14:12] are zero and imm12 is bits [11:0].
- Branch form: cond, op 8, and a signed 24-bit byte offset in bits [23:0].
- The no-operation word is 32'hED00_0000.

Top module: `cinsn_expander`

## Requirements
- R1: When cmp_mode_i is 0, insn_o equals fetch_i, illegal_o is 0, and hw_sel_i has no effect.
- R2: When cmp_mode_i is 1, hw_sel_i = 0 expands fetch_i[15:0] and hw_sel_i = 1 expands fetch_i[31:16].
- R3: A halfword with [15:9] = 7'b0001100 (add) or 7'b0001101 (subtract) expands to op 0 or op 1. rd comes from [2:0], rn from [5:3] and rm from [8:6].
- R4: Every 3-bit compressed register field maps to a full register number with bit 3 cleared, so only registers 0 to 7 are reached.
- R5: A halfword with [15:13] = 3'b001 is an immediate form: [12:11] selects 00 move, 01 compare, 10 add, and 11 is illegal. The register is [10:8] and imm8 is [7:0], zero-extended into imm12. Move writes rd with rn = 0. Compare uses rn with rd = 0. Add uses the register as both rd and rn.
- R6: All register and immediate expansions have S = 1.
- R7: Every expansion except a conditional branch carries cond 4'hE.
- R8: A halfword with [15:12] = 4'b1101 is a conditional branch with cond [11:8] and signed offset [7:0]. The offset is sign-extended and shifted left by 1 into bits [23:0]. Condition values 4'hE and 4'hF are illegal.
- R9: A halfword with [15:11] = 5'b11100 is an unconditional branch with signed offset [10:0], sign-extended and shifted left by 1, and cond 4'hE.
- R10: Any other compressed halfword gives insn_o = 32'hED00_0000. illegal_o is 1 in that case when valid_i is 1.
- R11: valid_o follows valid_i in the same cycle, and illegal_o is 0 whenever valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_i | input | 32 | Fetched word |
| hw_sel_i | input | 1 | Halfword choice in compressed mode |
| cmp_mode_i | input | 1 | 1 = compressed mode, 0 = full-width mode |
| valid_i | input | 1 | Fetch word is valid |
| insn_o | output | 32 | Full-width instruction for the decoder |
| valid_o | output | 1 | Instruction valid |
| illegal_o | output | 1 | Unsupported compressed encoding |

## Verification
The checks inside the design assume that each input has settled before it is evaluated. The bench therefore changes all inputs together away from the clock edge and reads the outputs one time unit later. The branch-condition assertion assumes the classifier has already rejected the condition values 4'hE and 4'hF. The stimulus includes those two values so that the rejection path is exercised and is not merely taken for granted. Some stimulus deliberately places illegal data in the half that is not selected, which shows that it cannot affect the result.

// File: rtl/cinsn_pkg.sv
package cinsn_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned CREG_W = 3;
  localparam int unsigned COND_W = 4;
  localparam int unsigned IMM_W  = 12;
  localparam int unsigned IMM8_W = 8;
  localparam int unsigned OFF_W  = 24;
  localparam int unsigned BODY_W = 12;

  localparam logic [COND_W-1:0] COND_AL = 4'hE;
  localparam logic [COND_W-1:0] COND_NV = 4'hF;

  typedef enum logic [3:0] {
    OP_ADD_R = 4'h0,
    OP_SUB_R = 4'h1,
    OP_MOV_I = 4'h2,
    OP_CMP_I = 4'h3,
    OP_ADD_I = 4'h4,
    OP_BR    = 4'h8,
    OP_NOP   = 4'hD
  } op_e;

  typedef enum logic [2:0] {
    CK_ADDR,
    CK_SUBR,
    CK_MOVI,
    CK_CMPI,
    CK_ADDI,
    CK_BCC,
    CK_B,
    CK_BAD
  } ckind_e;

  localparam logic [INSN_W-1:0] NOP_WORD = {COND_AL, OP_NOP, {OFF_W{1'b0}}};

  function automatic logic [REG_W-1:0] widen_reg(input logic [CREG_W-1:0] r);
    return {{(REG_W-CREG_W){1'b0}}, r};
  endfunction

  function automatic logic [INSN_W-1:0] fmt_reg(input op_e op, input logic [REG_W-1:0] rd,
                                                input logic [REG_W-1:0] rn,
                                                input logic [REG_W-1:0] rm);
    return {COND_AL, op, 1'b1, rd, rn, rm, 11'b0};
  endfunction

  function automatic logic [INSN_W-1:0] fmt_imm(input op_e op, input logic [REG_W-1:0] rd,
                                                input logic [REG_W-1:0] rn,
                                                input logic [IMM8_W-1:0] imm);
    return {COND_AL, op, 1'b1, rd, rn, 3'b0, {(IMM_W-IMM8_W){1'b0}}, imm};
  endfunction

  function automatic logic [INSN_W-1:0] fmt_br(input logic [COND_W-1:0] cond,
                                               input logic [OFF_W-1:0] off);
    return {cond, OP_BR, off};
  endfunction
endpackage

// File: rtl/cinsn_lane_pick.sv
module cinsn_lane_pick #(
  parameter int unsigned FETCH_W = 32,
  parameter int unsigned HALF_W  = 16,
  localparam int unsigned LANES  = FETCH_W / HALF_W,
  localparam int unsigned SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [FETCH_W-1:0] fetch_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [HALF_W-1:0]  half_o
);
  logic [HALF_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = fetch_i[g*HALF_W +: HALF_W];
  end

  assign half_o = lane[sel_i];
endmodule

// File: rtl/cinsn_classify.sv
module cinsn_classify
  import cinsn_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  output ckind_e            kind_o
);
  always_comb begin
    casez (half_i)
      16'b0001100?_????????: kind_o = CK_ADDR;
      16'b0001101?_????????: kind_o = CK_SUBR;
      16'b00100???_????????: kind_o = CK_MOVI;
      16'b00101???_????????: kind_o = CK_CMPI;
      16'b00110???_????????: kind_o = CK_ADDI;
      16'b1101????_????????: kind_o = (half_i[11:8] == COND_AL || half_i[11:8] == COND_NV)
                                      ? CK_BAD : CK_BCC;
      16'b11100???_????????: kind_o = CK_B;
      default:               kind_o = CK_BAD;
    endcase
  end
endmodule

// File: rtl/cinsn_expand.sv
module cinsn_expand
  import cinsn_pkg::*;
(
  input  ckind_e            kind_i,
  input  logic [BODY_W-1:0] body_i,
  output logic [INSN_W-1:0] insn_o
);
  logic [REG_W-1:0]  r_lo, r_mid, r_hi, r_imm;
  logic [OFF_W-1:0]  off_cc, off_uc;

  assign r_lo   = widen_reg(body_i[2:0]);
  assign r_mid  = widen_reg(body_i[5:3]);
  assign r_hi   = widen_reg(body_i[8:6]);
  assign r_imm  = widen_reg(body_i[10:8]);
  assign off_cc = {{(OFF_W-IMM8_W-1){body_i[7]}}, body_i[7:0], 1'b0};
  assign off_uc = {{(OFF_W-12){body_i[10]}}, body_i[10:0], 1'b0};

  always_comb begin
    unique case (kind_i)
      CK_ADDR: insn_o = fmt_reg(OP_ADD_R, r_lo, r_mid, r_hi);
      CK_SUBR: insn_o = fmt_reg(OP_SUB_R, r_lo, r_mid, r_hi);
      CK_MOVI: insn_o = fmt_imm(OP_MOV_I, r_imm, '0, body_i[7:0]);
      CK_CMPI: insn_o = fmt_imm(OP_CMP_I, '0, r_imm, body_i[7:0]);
      CK_ADDI: insn_o = fmt_imm(OP_ADD_I, r_imm, r_imm, body_i[7:0]);
      CK_BCC:  insn_o = fmt_br(body_i[11:8], off_cc);
      CK_B:    insn_o = fmt_br(COND_AL, off_uc);
      default: insn_o = NOP_WORD;
    endcase
  end

  always_comb begin
    if (kind_i != CK_BCC)
      AST_ALWAYS_COND: assert (insn_o[31:28] == COND_AL); // R7
    if (kind_i inside {CK_ADDR, CK_SUBR, CK_MOVI, CK_CMPI, CK_ADDI})
      AST_FLAG_SET: assert (insn_o[23]); // R6
    if (kind_i inside {CK_ADDR, CK_SUBR})
      AST_LOW_REGS: assert (!insn_o[22] && !insn_o[18] && !insn_o[14]); // R4
    if (kind_i inside {CK_MOVI, CK_CMPI, CK_ADDI})
      AST_IMM_ZEXT: assert (insn_o[11:8] == 4'h0 && !insn_o[22] && !insn_o[18]); // R5
    if (kind_i == CK_BCC)
      AST_COND_KEPT: assert (insn_o[31:28] != COND_AL && insn_o[31:28] != COND_NV); // R8
    if (kind_i inside {CK_BCC, CK_B})
      AST_BR_EVEN: assert (!insn_o[0] && insn_o[27:24] == OP_BR); // R9
  end
endmodule

// File: rtl/cinsn_expander.sv
module cinsn_expander
  import cinsn_pkg::*;
#(
  parameter int unsigned FETCH_W = 32,
  localparam int unsigned LANES  = FETCH_W / HALF_W,
  localparam int unsigned SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [FETCH_W-1:0] fetch_i,
  input  logic [SEL_W-1:0]   hw_sel_i,
  input  logic               cmp_mode_i,
  input  logic               valid_i,
  output logic [INSN_W-1:0]  insn_o,
  output logic               valid_o,
  output logic               illegal_o
);
  logic [HALF_W-1:0] half;
  ckind_e            kind;
  logic [INSN_W-1:0] expanded;

  cinsn_lane_pick #(
    .FETCH_W (FETCH_W),
    .HALF_W  (HALF_W)
  ) u_pick (
    .fetch_i (fetch_i),
    .sel_i   (hw_sel_i),
    .half_o  (half)
  );

  cinsn_classify u_class (
    .half_i (half),
    .kind_o (kind)
  );

  cinsn_expand u_expand (
    .kind_i (kind),
    .body_i (half[BODY_W-1:0]),
    .insn_o (expanded)
  );

  // mode mux: full words bypass the expansion path
  assign insn_o    = cmp_mode_i ? expanded : fetch_i[INSN_W-1:0];
  assign valid_o   = valid_i;
  assign illegal_o = valid_i & cmp_mode_i & (kind == CK_BAD);

  always_comb begin
    if (!cmp_mode_i)
      AST_PASS_THRU: assert (insn_o == fetch_i[INSN_W-1:0] && !illegal_o); // R1
    if (illegal_o)
      AST_BAD_NOP: assert (insn_o == NOP_WORD); // R10
    if (!valid_i)
      AST_QUIET_IDLE: assert (!illegal_o && !valid_o); // R11
  end
endmodule

// File: tb/cinsn_expander_bench.sv
module cinsn_expander_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_i = '0;
  logic        hw_sel_i = 1'b0;
  logic        cmp_mode_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] insn_o;
  logic        valid_o;
  logic        illegal_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] NOP = 32'hED00_0000;

  always #2 clk = ~clk; // 250 MHz

  cinsn_expander u_cinsn_expander (
    .fetch_i    (fetch_i),
    .hw_sel_i   (hw_sel_i),
    .cmp_mode_i (cmp_mode_i),
    .valid_i    (valid_i),
    .insn_o     (insn_o),
    .valid_o    (valid_o),
    .illegal_o  (illegal_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        mode;
    logic        hw;
    logic [31:0] fetch;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  1'b0, 1'b1, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R1
    '{4'd1,  1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R1 illegal-looking word passes
    '{4'd3,  1'b1, 1'b0, 32'hFFFF_18EA, 32'hE092_9800, 1'b0}, // R3 R6 R7 add r2,r5,r3
    '{4'd3,  1'b1, 1'b1, 32'h1BC7_0000, 32'hE1B8_3800, 1'b0}, // R3 sub r7,r0,r7
    '{4'd5,  1'b1, 1'b0, 32'h0000_24A5, 32'hE2A0_00A5, 1'b0}, // R5 R6 mov r4,#A5
    '{4'd5,  1'b1, 1'b0, 32'h0000_2EFF, 32'hE383_00FF, 1'b0}, // R5 cmp r6,#FF
    '{4'd5,  1'b1, 1'b1, 32'h3180_0000, 32'hE488_8080, 1'b0}, // R5 add r1,#80
    '{4'd10, 1'b1, 1'b0, 32'h0000_3800, NOP,           1'b1}, // R10 imm op 11
    '{4'd8,  1'b1, 1'b0, 32'h0000_D003, 32'h0800_0006, 1'b0}, // R8 cond 0, +6
    '{4'd8,  1'b1, 1'b0, 32'h0000_D180, 32'h18FF_FF00, 1'b0}, // R8 cond 1, -256
    '{4'd8,  1'b1, 1'b0, 32'h0000_DE05, NOP,           1'b1}, // R8 cond E rejected
    '{4'd8,  1'b1, 1'b1, 32'hDF00_0000, NOP,           1'b1}, // R8 cond F rejected
    '{4'd9,  1'b1, 1'b0, 32'h0000_E3FF, 32'hE800_07FE, 1'b0}, // R9 max forward
    '{4'd9,  1'b1, 1'b1, 32'hE400_0000, 32'hE8FF_F800, 1'b0}, // R9 max backward
    '{4'd10, 1'b1, 1'b0, 32'h0000_0000, NOP,           1'b1}, // R10
    '{4'd10, 1'b1, 1'b1, 32'hFFFF_0000, NOP,           1'b1}, // R10
    '{4'd10, 1'b1, 1'b0, 32'h0000_E800, NOP,           1'b1}, // R10 near-miss branch
    '{4'd2,  1'b1, 1'b0, 32'h24A5_D003, 32'h0800_0006, 1'b0}, // R2 lower half
    '{4'd2,  1'b1, 1'b1, 32'h24A5_D003, 32'hE2A0_00A5, 1'b0}, // R2 upper half
    '{4'd4,  1'b1, 1'b0, 32'h0000_19FF, 32'hE0BB_B800, 1'b0}  // R4 r7 everywhere
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic h, input logic [31:0] f, input logic v);
    @(negedge clk);
    cmp_mode_i = m;
    hw_sel_i   = h;
    fetch_i    = f;
    valid_i    = v;
    #1;
  endtask

  initial begin
    // reset state: nothing valid, nothing flagged (R11)
    repeat (3) @(negedge clk);
    check("R11 reset valid_o", {31'b0, valid_o}, 32'd0);
    check("R11 reset illegal_o", {31'b0, illegal_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].mode, VECS[i].hw, VECS[i].fetch, 1'b1);
      check($sformatf("R%0d vec%0d insn", VECS[i].req, i), insn_o, VECS[i].exp);
      check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), {31'b0, illegal_o}, {31'b0, VECS[i].ill});
      check($sformatf("R%0d vec%0d valid", VECS[i].req, i), {31'b0, valid_o}, 32'd1);
    end

    // R1: hw_sel_i ignored in full mode
    drive(1'b0, 1'b0, 32'hCAFE_0123, 1'b1);
    check("R1 full hw0", insn_o, 32'hCAFE_0123);
    drive(1'b0, 1'b1, 32'hCAFE_0123, 1'b1);
    check("R1 full hw1", insn_o, 32'hCAFE_0123);

    // R11: illegal pattern with valid low raises nothing, valid tracks in the same cycle
    drive(1'b1, 1'b0, 32'h0000_0000, 1'b0);
    check("R11 idle illegal_o", {31'b0, illegal_o}, 32'd0);
    check("R11 idle valid_o", {31'b0, valid_o}, 32'd0);
    check("R10 idle still nop", insn_o, NOP);
    drive(1'b1, 1'b0, 32'h0000_0000, 1'b1);
    check("R11 valid same cycle", {31'b0, valid_o}, 32'd1);
    check("R10 flag when valid", {31'b0, illegal_o}, 32'd1);

    // R7: unconditional branch of zero offset still always-executes
    drive(1'b1, 1'b1, 32'hE000_0000, 1'b1);
    check("R7 uncond cond field", insn_o, 32'hE800_0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule